// File: doc/BRIEF.md
# Serial configuration bitstream frame parser

This block takes a configuration bitstream one bit per clock, qualified by a valid strobe, and takes it apart. It waits through any run of padding ones for the four-bit start pattern, reads the 24-bit length word, and checks that a run of padding ones follows before the first frame. After that it handles a sequence of frames. Each frame opens with a single zero, then carries a two-bit control pair, two parity bits, an 11-bit column address and a body.

A frame whose address is all ones is the identification frame. It carries a parity-enable bit, a reserved field that must read zero, and a 20-bit part code. Other frames are either compressed, which means the address alone, or full. A full frame adds a fixed run of alignment zeros, a write bit and a data field. The sizes of the alignment run and the data field are parameters, because they depend on the target device. A fixed 16-bit closing word ends the stream, and the block then ignores the trailing padding.

Each finished data frame gives a one-cycle strobe with its address, data, compressed flag and write bit. The length, part code and parity-enable setting stay on the outputs once captured. A grammar fault sets a sticky format flag and sends the parser back to looking for the start pattern. A parity mismatch sets a sticky parity flag.

Top module: `cfg_stream_parser`

## Requirements
- R1: The start pattern 0,0,1,0 is accepted only when at least 4 consecutive ones come before it. A start pattern that has fewer leading ones is ignored and does not raise the format flag.
- R2: The 24 bits after the start pattern are the length, most significant bit first. They appear on `length_count`, and `length_valid` rises one cycle after the 24th bit.
- R3: Between the length and the first frame's zero start bit there must be at least 4 ones. If there are fewer, `fmt_err` is raised.
- R4: Each frame is read in this order: a start bit of 0, then P, C, Opar, Epar, then an 11-bit address with the most significant bit first. `frame_valid` is high for exactly one cycle, namely the cycle after the last bit of a data frame, and it carries that frame's fields.
- R5: A data frame with C=0 carries, after the address, ALIGN_ZEROS zeros, one write bit, and DATA_W data bits with the most significant bit first. A 1 in the alignment run raises `fmt_err` and delivers no frame.
- R6: A data frame with C=1 ends right after its address. It is reported with `frame_compressed`=1, `frame_data`=0 and `frame_write`=0.
- R7: A frame whose address is 11 ones and whose header is not the closing word is the identification frame. It must have P=1 and C=0. Its body is one parity-enable bit, then 43 bits that must be 0, then a 20-bit part code with the most significant bit first. `id_valid`, `part_id` and `parity_en` update one cycle after its last bit. A wrong P/C pair or a nonzero reserved bit raises `fmt_err` and leaves `id_valid` low.
- R8: The next start bit must come after at least 3 ones following an identification frame, and after at least 1 one following a data frame. An earlier 0 raises `fmt_err`.
- R9: While `parity_en` is 1, the frame bits are numbered from 0, starting at P and skipping Opar and Epar. A frame is correct when the XOR of its even-numbered bits together with Opar is 1, and the XOR of its odd-numbered bits together with Epar is 0. If a frame is not correct, `parity_err` is set and the frame is still delivered. While `parity_en` is 0, no parity error is raised.
- R10: A frame header equal to the 16-bit word 0010011111111111 (start bit included, P=0, C=1) sets `done` one cycle after its last bit. From then on, every input is ignored until reset.
- R11: `fmt_err` and `parity_err` stay set until reset. After a format fault the parser looks for a new start pattern, and a complete stream that follows is parsed normally.
- R12: Cycles with `bit_valid` low change nothing. A stream with idle gaps gives the same results as the same stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial stream bit |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| length_count | output | 24 | Captured length word |
| length_valid | output | 1 | Length word has been captured |
| part_id | output | 20 | Captured part code |
| id_valid | output | 1 | Identification frame accepted |
| parity_en | output | 1 | Parity checking enabled by the identification frame |
| frame_valid | output | 1 | One-cycle strobe per finished data frame |
| frame_addr | output | 11 | Column address of the frame |
| frame_data | output | DATA_W | Data field of the frame (0 when compressed) |
| frame_compressed | output | 1 | Frame carried an address only |
| frame_write | output | 1 | Write bit of the frame |
| fmt_err | output | 1 | Sticky grammar fault |
| parity_err | output | 1 | Sticky parity mismatch |
| done | output | 1 | Closing word seen |

## Verification
The bench targets the places where an off-by-one in the grammar changes what the parser does:
- **Leading padding of exactly 3 ones versus 4.** A counter that is too lenient locks onto the short preamble and reports a length.
- **Trailing padding of 3 ones.** A parser that misses this walks into the first frame with no fault flagged.
- **Two stop bits after the identification frame, and zero stop bits after a data frame.** Getting either wrong lets a frame through where `fmt_err` should be set.
- **Streams with parity enabled, including one frame with a deliberately bad parity bit.** Random compressed and full frames are mixed in. A wrong bit numbering, or counting the parity bits themselves, raises false parity errors, misses the bad frame, or shifts address and data by one position.
- **Input after the closing word, and a stream with heavy idle gaps.** A parser that keeps running after the closing word emits extra frames. A parser that advances on idle cycles corrupts every captured field.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_PRE,
    ST_LEN,
    ST_TRAIL,
    ST_HDR,
    ST_ID,
    ST_ALIGN,
    ST_WBIT,
    ST_DATA,
    ST_STOP,
    ST_DONE
  } cfgp_state_e;

  localparam int LEN_W          = 24;
  localparam int ADDR_W         = 11;
  localparam int HDR_W          = 15;   // P, C, Opar, Epar, address
  localparam int PART_W         = 20;
  localparam int RSV_W          = 43;
  localparam int ID_BODY_W      = 1 + RSV_W + PART_W;
  localparam int LEAD_MIN       = 4;
  localparam int TRAIL_MIN      = 4;
  localparam int STOP_AFTER_ID  = 3;
  localparam int STOP_AFTER_DAT = 1;
  localparam int RUN_SAT        = 4;

  // header bits that follow the zero start bit of the closing word
  localparam logic [HDR_W-1:0] CLOSE_HDR = 15'b010011111111111;

  // even-position XOR combined with Opar must be 1,
  // odd-position XOR combined with Epar must be 0
  function automatic logic parity_ok(input logic x_even, input logic x_odd,
                                     input logic opar, input logic epar);
    return (x_even ^ opar) & ~(x_odd ^ epar);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfgp_run_cnt.sv
module cfgp_run_cnt #(
  parameter int SAT = 4,
  localparam int W = $clog2(SAT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         one,
  output logic [W-1:0] run
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run <= '0;
    end else if (step) begin
      if (!one)                run <= '0;
      else if (run != W'(SAT)) run <= run + 1'b1;
    end
  end

endmodule

// File: rtl/cfgp_par_acc.sv
module cfgp_par_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic din,
  output logic x_even_nx,
  output logic x_odd_nx
);

  logic x_even_q, x_odd_q, odd_pos_q;

  assign x_even_nx = x_even_q ^ (step & ~odd_pos_q & din);
  assign x_odd_nx  = x_odd_q  ^ (step &  odd_pos_q & din);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x_even_q  <= 1'b0;
      x_odd_q   <= 1'b0;
      odd_pos_q <= 1'b0;
    end else if (step) begin
      x_even_q  <= x_even_nx;
      x_odd_q   <= x_odd_nx;
      odd_pos_q <= ~odd_pos_q;
    end
  end

endmodule

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (step) q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter int ALIGN_ZEROS = 3,
  parameter int DATA_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_in,
  input  logic                       bit_valid,
  output logic [LEN_W-1:0]           length_count,
  output logic                       length_valid,
  output logic [PART_W-1:0]          part_id,
  output logic                       id_valid,
  output logic                       parity_en,
  output logic                       frame_valid,
  output logic [ADDR_W-1:0]          frame_addr,
  output logic [DATA_W-1:0]          frame_data,
  output logic                       frame_compressed,
  output logic                       frame_write,
  output logic                       fmt_err,
  output logic                       parity_err,
  output logic                       done
);

  localparam int SH_W      = (DATA_W > LEN_W) ? DATA_W : LEN_W;
  localparam int MAX_FIELD = max3(ID_BODY_W, SH_W, ALIGN_ZEROS);
  localparam int CNT_W     = $clog2(MAX_FIELD);
  localparam int RUN_W     = $clog2(RUN_SAT + 1);
  localparam int PART_POS  = 1 + RSV_W;

  cfgp_state_e        st_q, st_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_nx;
  logic [RUN_W-1:0]   run_q;
  logic [RUN_W-1:0]   stop_min_q;
  logic [SH_W-2:0]    sh_q;
  logic [SH_W-1:0]    sh_nx;
  logic [HDR_W-2:0]   hdr_q;
  logic [HDR_W-1:0]   hdr_full;
  logic               pen_q, wr_q;
  logic               x_even_nx, x_odd_nx;

  // named internal events
  logic ev_pre, ev_len, ev_fstart, ev_frame_end, ev_comp_end;
  logic ev_id_end, ev_close, ev_err;
  logic run_clr, par_step, sh_step, hdr_step, pen_cap, wr_cap;

  assign sh_nx    = {sh_q, bit_in};
  assign hdr_full = {hdr_q, bit_in};

  cfgp_run_cnt #(.SAT(RUN_SAT)) u_run (
    .clk (clk), .rst_n (rst_n), .clr (run_clr),
    .step(bit_valid), .one (bit_in), .run (run_q)
  );

  cfgp_par_acc u_par (
    .clk (clk), .rst_n (rst_n), .clr (ev_fstart),
    .step(par_step), .din (bit_in),
    .x_even_nx(x_even_nx), .x_odd_nx(x_odd_nx)
  );

  cfgp_shreg #(.W(SH_W-1)) u_sh (
    .clk(clk), .rst_n(rst_n), .step(sh_step), .din(bit_in), .q(sh_q)
  );

  cfgp_shreg #(.W(HDR_W-1)) u_hdr (
    .clk(clk), .rst_n(rst_n), .step(hdr_step), .din(bit_in), .q(hdr_q)
  );

  always_comb begin
    st_nx        = st_q;
    cnt_nx       = cnt_q;
    ev_pre       = 1'b0;
    ev_len       = 1'b0;
    ev_fstart    = 1'b0;
    ev_frame_end = 1'b0;
    ev_comp_end  = 1'b0;
    ev_id_end    = 1'b0;
    ev_close     = 1'b0;
    ev_err       = 1'b0;
    run_clr      = 1'b0;
    par_step     = 1'b0;
    sh_step      = 1'b0;
    hdr_step     = 1'b0;
    pen_cap      = 1'b0;
    wr_cap       = 1'b0;
    if (bit_valid) begin
      case (st_q)
        ST_HUNT: begin
          if (!bit_in && run_q >= RUN_W'(LEAD_MIN)) begin
            st_nx  = ST_PRE;
            cnt_nx = '0;
          end
        end
        ST_PRE: begin
          // remaining pattern bits after the first zero: 0, 1, 0
          if (bit_in != (cnt_q == CNT_W'(1))) begin
            st_nx = ST_HUNT;
          end else if (cnt_q == CNT_W'(2)) begin
            ev_pre = 1'b1;
            st_nx  = ST_LEN;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        ST_LEN: begin
          sh_step = 1'b1;
          if (cnt_q == CNT_W'(LEN_W - 1)) begin
            ev_len  = 1'b1;
            st_nx   = ST_TRAIL;
            run_clr = 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        ST_TRAIL, ST_STOP: begin
          if (!bit_in) begin
            if (run_q >= ((st_q == ST_TRAIL) ? RUN_W'(TRAIL_MIN) : stop_min_q)) begin
              ev_fstart = 1'b1;
              st_nx     = ST_HDR;
              cnt_nx    = '0;
            end else begin
              ev_err = 1'b1;
            end
          end
        end
        ST_HDR: begin
          hdr_step = 1'b1;
          par_step = (cnt_q != CNT_W'(2)) && (cnt_q != CNT_W'(3));
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_nx = '0;
            if (hdr_full == CLOSE_HDR) begin
              ev_close = 1'b1;
              st_nx    = ST_DONE;
            end else if (&hdr_full[ADDR_W-1:0]) begin
              if (hdr_full[14] && !hdr_full[13]) st_nx = ST_ID;
              else                               ev_err = 1'b1;
            end else if (!hdr_full[14]) begin
              ev_err = 1'b1;
            end else if (hdr_full[13]) begin
              ev_frame_end = 1'b1;
              ev_comp_end  = 1'b1;
              st_nx        = ST_STOP;
              run_clr      = 1'b1;
            end else begin
              st_nx = ST_ALIGN;
            end
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        ST_ID: begin
          pen_cap = (cnt_q == '0);
          sh_step = (cnt_q >= CNT_W'(PART_POS));
          if (cnt_q != '0 && cnt_q < CNT_W'(PART_POS) && bit_in) begin
            ev_err = 1'b1;
          end else if (cnt_q == CNT_W'(ID_BODY_W - 1)) begin
            ev_id_end = 1'b1;
            st_nx     = ST_STOP;
            run_clr   = 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        ST_ALIGN: begin
          par_step = 1'b1;
          if (bit_in) begin
            ev_err = 1'b1;
          end else if (cnt_q == CNT_W'(ALIGN_ZEROS - 1)) begin
            st_nx  = ST_WBIT;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        ST_WBIT: begin
          par_step = 1'b1;
          wr_cap   = 1'b1;
          st_nx    = ST_DATA;
          cnt_nx   = '0;
        end
        ST_DATA: begin
          par_step = 1'b1;
          sh_step  = 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            ev_frame_end = 1'b1;
            st_nx        = ST_STOP;
            run_clr      = 1'b1;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
      if (ev_err) begin
        st_nx   = ST_HUNT;
        cnt_nx  = '0;
        run_clr = 1'b1;
      end
    end
  end

  logic opar_sel, epar_sel, par_bad;
  assign opar_sel = ev_comp_end ? hdr_full[12] : hdr_q[12];
  assign epar_sel = ev_comp_end ? hdr_full[11] : hdr_q[11];
  assign par_bad  = parity_en & ~parity_ok(x_even_nx, x_odd_nx, opar_sel, epar_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q             <= ST_HUNT;
      cnt_q            <= '0;
      stop_min_q       <= RUN_W'(STOP_AFTER_DAT);
      pen_q            <= 1'b0;
      wr_q             <= 1'b0;
      length_count     <= '0;
      length_valid     <= 1'b0;
      part_id          <= '0;
      id_valid         <= 1'b0;
      parity_en        <= 1'b0;
      frame_valid      <= 1'b0;
      frame_addr       <= '0;
      frame_data       <= '0;
      frame_compressed <= 1'b0;
      frame_write      <= 1'b0;
      fmt_err          <= 1'b0;
      parity_err       <= 1'b0;
      done             <= 1'b0;
    end else begin
      st_q        <= st_nx;
      cnt_q       <= cnt_nx;
      frame_valid <= ev_frame_end;
      if (pen_cap) pen_q <= bit_in;
      if (wr_cap)  wr_q  <= bit_in;
      if (ev_len) begin
        length_count <= sh_nx[LEN_W-1:0];
        length_valid <= 1'b1;
      end
      if (ev_id_end) begin
        part_id    <= sh_nx[PART_W-1:0];
        id_valid   <= 1'b1;
        parity_en  <= pen_q;
        stop_min_q <= RUN_W'(STOP_AFTER_ID);
      end
      if (ev_frame_end) begin
        stop_min_q <= RUN_W'(STOP_AFTER_DAT);
        if (ev_comp_end) begin
          frame_addr       <= hdr_full[ADDR_W-1:0];
          frame_data       <= '0;
          frame_compressed <= 1'b1;
          frame_write      <= 1'b0;
        end else begin
          frame_addr       <= hdr_q[ADDR_W-1:0];
          frame_data       <= sh_nx[DATA_W-1:0];
          frame_compressed <= hdr_q[13];
          frame_write      <= wr_q;
        end
        if (par_bad) parity_err <= 1'b1;
      end
      if (ev_err)   fmt_err <= 1'b1;
      if (ev_close) done    <= 1'b1;
    end
  end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_valid,
  input logic              frame_valid,
  input logic              frame_compressed,
  input logic              frame_write,
  input logic [DATA_W-1:0] frame_data,
  input logic [23:0]       length_count,
  input logic              length_valid,
  input logic [19:0]       part_id,
  input logic              id_valid,
  input logic              fmt_err,
  input logic              parity_err,
  input logic              done,
  input logic              ev_err
);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_comp_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_compressed) |-> (frame_data == '0 && !frame_write));

  p_frame_needs_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> length_valid);

  p_id_needs_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> length_valid);

  p_fmt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  p_fault_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> fmt_err);

  p_par_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> parity_err);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !frame_valid));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!frame_valid && $stable(length_count) && $stable(part_id)));

endmodule

bind cfg_stream_parser cfgp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bit_valid        (bit_valid),
  .frame_valid      (frame_valid),
  .frame_compressed (frame_compressed),
  .frame_write      (frame_write),
  .frame_data       (frame_data),
  .length_count     (length_count),
  .length_valid     (length_valid),
  .part_id          (part_id),
  .id_valid         (id_valid),
  .fmt_err          (fmt_err),
  .parity_err       (parity_err),
  .done             (done),
  .ev_err           (ev_err)
);

// File: tb/cfg_stream_parser_bench.sv
`timescale 1ns/1ps
module cfg_stream_parser_bench;

  localparam int AZ = 3;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, bit_in = 1'b0, bit_valid = 1'b0;
  logic [23:0]   length_count;
  logic          length_valid;
  logic [19:0]   part_id;
  logic          id_valid, parity_en, frame_valid;
  logic [10:0]   frame_addr;
  logic [DW-1:0] frame_data;
  logic          frame_compressed, frame_write, fmt_err, parity_err, done;

  always #2 clk = ~clk;

  cfg_stream_parser #(.ALIGN_ZEROS(AZ), .DATA_W(DW)) u_cfg_stream_parser (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .length_count(length_count), .length_valid(length_valid),
    .part_id(part_id), .id_valid(id_valid), .parity_en(parity_en),
    .frame_valid(frame_valid), .frame_addr(frame_addr), .frame_data(frame_data),
    .frame_compressed(frame_compressed), .frame_write(frame_write),
    .fmt_err(fmt_err), .parity_err(parity_err), .done(done)
  );

  int n_chk = 0, n_err = 0;
  bit sq[$];
  logic [10:0] e_addr[$], o_addr[$];
  logic [DW-1:0] e_data[$], o_data[$];
  bit e_comp[$], o_comp[$], e_wr[$], o_wr[$];

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      o_addr.push_back(frame_addr);
      o_data.push_back(frame_data);
      o_comp.push_back(frame_compressed);
      o_wr.push_back(frame_write);
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    sq.delete();
    e_addr.delete(); e_data.delete(); e_comp.delete(); e_wr.delete();
    repeat (3) @(negedge clk);
    o_addr.delete(); o_data.delete(); o_comp.delete(); o_wr.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic void put_ones(int n);
    for (int i = 0; i < n; i++) sq.push_back(1'b1);
  endfunction

  function automatic void put_val(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sq.push_back(v[i]);
  endfunction

  function automatic void put_head(int lead, logic [23:0] len, int trail);
    put_ones(lead); put_val(64'b0010, 4); put_val(len, 24); put_ones(trail);
  endfunction

  function automatic void put_id(bit pen, logic [19:0] id, int bad_rsv, bit p, bit c, int stops);
    sq.push_back(1'b0); sq.push_back(p); sq.push_back(c);
    sq.push_back(1'b0); sq.push_back(1'b0);
    put_val(64'h7FF, 11);
    sq.push_back(pen);
    for (int i = 0; i < 43; i++) sq.push_back(i == bad_rsv);
    put_val(id, 20);
    put_ones(stops);
  endfunction

  // builds a frame with its parity bits worked out from the numbered body
  function automatic void put_data(logic [10:0] a, bit comp, bit wr, logic [DW-1:0] d,
                                   bit bad_par, int stops, int bad_align, bit rec);
    bit fb[$];
    bit xe, xo;
    fb.push_back(1'b1); fb.push_back(comp);
    for (int i = 10; i >= 0; i--) fb.push_back(a[i]);
    if (!comp) begin
      for (int i = 0; i < AZ; i++) fb.push_back(i == bad_align);
      fb.push_back(wr);
      for (int i = DW - 1; i >= 0; i--) fb.push_back(d[i]);
    end
    xe = 1'b0; xo = 1'b0;
    for (int i = 0; i < fb.size(); i++) begin
      if (i % 2 == 0) xe ^= fb[i];
      else            xo ^= fb[i];
    end
    sq.push_back(1'b0); sq.push_back(fb[0]); sq.push_back(fb[1]);
    sq.push_back(~xe ^ bad_par); sq.push_back(xo);
    for (int i = 2; i < fb.size(); i++) sq.push_back(fb[i]);
    put_ones(stops);
    if (rec) begin
      e_addr.push_back(a);
      e_data.push_back(comp ? '0 : d);
      e_comp.push_back(comp);
      e_wr.push_back(comp ? 1'b0 : wr);
    end
  endfunction

  function automatic void put_rand_frames(int n);
    for (int k = 0; k < n; k++)
      put_data(11'($urandom_range(0, 2046)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               DW'($urandom), 1'b0, $urandom_range(1, 4), -1, 1'b1);
  endfunction

  function automatic void put_close();
    put_val(64'h27FF, 16); put_ones(8);
  endfunction

  task automatic play(int gap_pct);
    for (int i = 0; i < sq.size(); i++) begin
      for (int g = 0; g < 3; g++) begin
        if ($urandom_range(0, 99) < gap_pct) begin
          bit_valid = 1'b0; bit_in = 1'($urandom);
          @(negedge clk);
        end
      end
      bit_valid = 1'b1; bit_in = sq[i];
      @(negedge clk);
    end
    bit_valid = 1'b0;
    sq.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_frames();
    chk("R4", "frame count", 64'(o_addr.size()), 64'(e_addr.size()));
    for (int i = 0; i < e_addr.size() && i < o_addr.size(); i++) begin
      chk("R4", "frame address", 64'(o_addr[i]), 64'(e_addr[i]));
      chk("R6", "compressed flag", 64'(o_comp[i]), 64'(e_comp[i]));
      chk("R5", "frame data", 64'(o_data[i]), 64'(e_data[i]));
      chk("R5", "write bit", 64'(o_wr[i]), 64'(e_wr[i]));
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));

    // reset state
    do_reset();
    chk("R2", "length_valid after reset", 64'(length_valid), 0);
    chk("R10", "done after reset", 64'(done), 0);
    chk("R11", "fmt_err after reset", 64'(fmt_err), 0);
    chk("R4", "frame_valid after reset", 64'(frame_valid), 0);

    // main stream, parity on, mixed frames
    do_reset();
    put_head(6, 24'hA5C3E1, 5);
    put_id(1'b1, 20'hB3C5D, -1, 1'b1, 1'b0, 3);
    put_rand_frames(24);
    put_close();
    play(25);
    chk("R2", "length", 64'(length_count), 64'h A5C3E1);
    chk("R2", "length_valid", 64'(length_valid), 1);
    chk("R7", "part id", 64'(part_id), 64'h B3C5D);
    chk("R7", "parity enable", 64'(parity_en), 1);
    chk("R7", "id_valid", 64'(id_valid), 1);
    cmp_frames();
    chk("R9", "no parity error", 64'(parity_err), 0);
    chk("R8", "no format error", 64'(fmt_err), 0);
    chk("R10", "done", 64'(done), 1);
    // input after the closing word is ignored
    put_head(5, 24'h111111, 4);
    put_data(11'h055, 1'b1, 1'b0, '0, 1'b0, 2, -1, 1'b0);
    play(0);
    chk("R10", "frames after done", 64'(o_addr.size()), 64'(e_addr.size()));
    chk("R10", "length after done", 64'(length_count), 64'h A5C3E1);

    // heavy idle gaps, parity off
    do_reset();
    put_head(4, 24'h00C0DE, 4);
    put_rand_frames(10);
    put_close();
    play(70);
    chk("R12", "length with gaps", 64'(length_count), 64'h00C0DE);
    cmp_frames();
    chk("R12", "done with gaps", 64'(done), 1);

    // only 3 leading ones: no lock, then a proper stream
    do_reset();
    put_ones(3); put_val(64'b0010, 4); put_val(0, 30);
    play(0);
    chk("R1", "no lock after 3 ones", 64'(length_valid), 0);
    chk("R1", "no fault on short lead", 64'(fmt_err), 0);
    put_head(4, 24'h5A5A5A, 4);
    play(0);
    chk("R1", "lock after 4 ones", 64'(length_count), 64'h5A5A5A);

    // short trailing run, then recovery
    do_reset();
    put_head(4, 24'h123456, 3); sq.push_back(1'b0);
    play(0);
    chk("R3", "fault on 3 trailing ones", 64'(fmt_err), 1);
    put_head(5, 24'h0F0F0F, 4);
    put_rand_frames(3);
    put_close();
    play(10);
    chk("R11", "length after recovery", 64'(length_count), 64'h0F0F0F);
    cmp_frames();
    chk("R11", "fault stays set", 64'(fmt_err), 1);
    chk("R11", "done after recovery", 64'(done), 1);

    // alignment one
    do_reset();
    put_head(4, 24'h000001, 4);
    put_data(11'h123, 1'b0, 1'b0, '0, 1'b0, 1, 1, 1'b0);
    play(0);
    chk("R5", "fault on alignment one", 64'(fmt_err), 1);
    chk("R5", "no frame on alignment one", 64'(o_addr.size()), 0);

    // nonzero reserved bit
    do_reset();
    put_head(4, 24'h000002, 4);
    put_id(1'b0, 20'h0, 10, 1'b1, 1'b0, 3);
    play(0);
    chk("R7", "fault on reserved bit", 64'(fmt_err), 1);
    chk("R7", "id rejected", 64'(id_valid), 0);

    // ID frame with C=1
    do_reset();
    put_head(4, 24'h000003, 4);
    put_id(1'b0, 20'h0, -1, 1'b1, 1'b1, 3);
    play(0);
    chk("R7", "fault on ID control pair", 64'(fmt_err), 1);

    // two stops after ID
    do_reset();
    put_head(4, 24'h000004, 4);
    put_id(1'b0, 20'h0, -1, 1'b1, 1'b0, 2);
    put_data(11'h000, 1'b1, 1'b0, '0, 1'b0, 1, -1, 1'b0);
    play(0);
    chk("R8", "fault on two stops after ID", 64'(fmt_err), 1);
    chk("R8", "no frame after short stop", 64'(o_addr.size()), 0);

    // zero stops after data frame
    do_reset();
    put_head(4, 24'h000005, 4);
    put_data(11'h0A0, 1'b1, 1'b0, '0, 1'b0, 0, -1, 1'b1);
    put_data(11'h000, 1'b1, 1'b0, '0, 1'b0, 1, -1, 1'b0);
    play(0);
    chk("R8", "fault on missing stop", 64'(fmt_err), 1);
    chk("R8", "first frame delivered", 64'(o_addr.size()), 1);

    // bad parity with checking on
    do_reset();
    put_head(4, 24'h000006, 4);
    put_id(1'b1, 20'h12345, -1, 1'b1, 1'b0, 3);
    put_data(11'h3C3, 1'b0, 1'b1, 16'hBEEF, 1'b1, 2, -1, 1'b1);
    put_close();
    play(0);
    chk("R9", "parity error flagged", 64'(parity_err), 1);
    cmp_frames();

    // bad parity with checking off
    do_reset();
    put_head(4, 24'h000007, 4);
    put_id(1'b0, 20'h12345, -1, 1'b1, 1'b0, 3);
    put_data(11'h3C3, 1'b1, 1'b0, '0, 1'b1, 2, -1, 1'b1);
    put_close();
    play(0);
    chk("R9", "no parity error when off", 64'(parity_err), 0);
    chk("R9", "frame still delivered", 64'(o_addr.size()), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule